// File: doc/BRIEF.md
# Host Memory Access Port

This block lets an outside master borrow a processor's on-chip word store. The master pulls an active-low request line. After a fixed, parameterised number of clock cycles the block pulls its active-low grant line low. While grant is low, the master runs strobed transfers: it presents an address, a direction select (high for read, low for write), write data when writing, and then drives an active-low strobe. Writes land in the internal store. Reads load a word into a read-data register, which feeds the shared data lines.

The data lines are turned on only when three conditions hold: grant is low, the synchronised direction select is high, and the raw select pin is high. Because the raw pin is in that gate, a falling select removes the drive at once. Request, strobe and select all pass through a synchroniser chain. Address and write data travel through a matching chain, so they stay aligned with the strobe edge detector. A release asked for while a transfer's strobe is still low is held off until the strobe returns high.

Top module: `host_mem_port`

## Requirements
- R1: After reset, grant is high, the data output enable is low and the read-data output is zero.
- R2: Grant falls at the (SYNC_STAGES+1+GRANT_ON_DLY)th rising clock edge after the request falls. A request that returns high before that edge produces no grant.
- R3: With the strobe high, grant rises at the (SYNC_STAGES+1+GRANT_OFF_DLY)th rising edge after the request rises.
- R4: While the synchronised strobe is low, a raised request does not release grant. Grant then rises at the (SYNC_STAGES+1+GRANT_OFF_DLY)th edge after the strobe rises.
- R5: The output enable is high only while grant is low, the select is high (1 = read) and the synchronised select is high. It rises at the SYNC_STAGES-th edge after the select rises. It falls without waiting for a clock when the select pin goes low, so it is never high while the select indicates write.
- R6: The output enable falls in the same cycle that grant rises.
- R7: Each strobe fall seen while grant is low and the select is low (write) stores the write data at the addressed word. Address and data are the values present at the first rising edge after the strobe falls; later changes have no effect.
- R8: A strobe fall while grant is high changes no stored word.
- R9: Each strobe fall seen while grant is low and the select is high loads the addressed word onto the read-data output at the (SYNC_STAGES+1)th edge after the fall. The output holds that value after the strobe rises, until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req_n | input | 1 | Active-low bus request from the host |
| host_grant_n | output | 1 | Active-low access granted |
| host_strobe_n | input | 1 | Active-low transfer strobe |
| host_rw | input | 1 | Direction select, 1 = read, 0 = write |
| host_addr | input | ADDR_W | Word address |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Read data toward the shared bus |
| host_rdata_oe | output | 1 | Drive enable for the shared bus |

## Verification
The bench builds the block with a 4-bit address and 12-bit words. With these values the whole 16-word store is written and read back twice, with two arithmetic patterns that are complements of each other. Grant delays of 3 cycles on and 2 off differ from the defaults, so the latency formula is checked with unequal terms. A request pulse of two cycles ends inside the arming window, which makes the abort path reachable. Two synchroniser stages leave room to move the address one cycle after the strobe falls, and to drop the select pin between edges.

// File: rtl/hmp_pkg.sv
package hmp_pkg;

   typedef enum logic [1:0] {
      GS_IDLE      = 2'd0,
      GS_ARMING    = 2'd1,
      GS_HELD      = 2'd2,
      GS_RELEASING = 2'd3
   } grant_state_e;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/hmp_sync.sv
module hmp_sync #(
   parameter int unsigned W = 1,
   parameter int unsigned STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hmp_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("hmp_sync: W must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{RST_VAL}};
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d};
      end
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/hmp_grant_ctl.sv
module hmp_grant_ctl
   import hmp_pkg::*;
#(
   parameter int unsigned ON_DLY  = 2,
   parameter int unsigned OFF_DLY = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_act,
   input  logic stb_idle,
   output logic granted
);

   localparam int unsigned MAXD = max2(ON_DLY, OFF_DLY);
   localparam int unsigned CW   = (MAXD < 2) ? 1 : $clog2(MAXD);
   localparam logic [CW-1:0] ON_LAST  = CW'(ON_DLY - 1);
   localparam logic [CW-1:0] OFF_LAST = CW'(OFF_DLY - 1);

   generate
      if (ON_DLY < 1 || OFF_DLY < 1) begin : g_bad_dly
         $error("hmp_grant_ctl: delays must be at least 1");
      end
   endgenerate

   grant_state_e state_q, state_d;
   logic [CW-1:0] cnt_q, cnt_d;

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      unique case (state_q)
         GS_IDLE: begin
            if (req_act) begin
               state_d = GS_ARMING;
               cnt_d   = '0;
            end
         end
         GS_ARMING: begin
            if (!req_act) begin
               state_d = GS_IDLE;
            end else if (cnt_q == ON_LAST) begin
               state_d = GS_HELD;
            end else begin
               cnt_d = cnt_q + CW'(1);
            end
         end
         GS_HELD: begin
            if (!req_act && stb_idle) begin
               state_d = GS_RELEASING;
               cnt_d   = '0;
            end
         end
         GS_RELEASING: begin
            if (cnt_q == OFF_LAST) begin
               state_d = GS_IDLE;
            end else begin
               cnt_d = cnt_q + CW'(1);
            end
         end
         default: state_d = GS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= GS_IDLE;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

   assign granted = (state_q == GS_HELD) || (state_q == GS_RELEASING);

   p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      32'(cnt_q) < MAXD)
      else $error("delay counter out of range");

   p_strobe_holds_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == GS_HELD && !stb_idle) |=> granted)
      else $error("grant released during strobe");

endmodule

// File: rtl/hmp_store.sv
module hmp_store #(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic              re,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata_q
);

   localparam int unsigned DEPTH = 1 << ADDR_W;

   generate
      if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr
         $error("hmp_store: ADDR_W out of range");
      end
   endgenerate

   logic [DATA_W-1:0] words [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         words[addr] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (re) begin
         rdata_q <= words[addr];
      end
   end

   p_read_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rdata_q) |-> $past(re))
      else $error("read data changed without a read");

endmodule

// File: rtl/host_mem_port.sv
module host_mem_port #(
   parameter int unsigned ADDR_W        = 4,
   parameter int unsigned DATA_W        = 16,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter int unsigned GRANT_ON_DLY  = 2,
   parameter int unsigned GRANT_OFF_DLY = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_req_n,
   output logic              host_grant_n,
   input  logic              host_strobe_n,
   input  logic              host_rw,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              host_rdata_oe
);

   localparam int unsigned PW = ADDR_W + DATA_W;

   generate
      if (DATA_W < 1) begin : g_bad_data
         $error("host_mem_port: DATA_W must be at least 1");
      end
   endgenerate

   // control bundle: {request_n, strobe_n, rw}, idle value 1,1,0
   logic [2:0]        ctrl_s;
   logic [PW-1:0]     pay_s;
   logic              req_s_n, stb_s_n, rw_s;
   logic [ADDR_W-1:0] addr_s;
   logic [DATA_W-1:0] wdata_s;

   hmp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_ctrl_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({host_req_n, host_strobe_n, host_rw}),
      .q     (ctrl_s)
   );

   // payload rides alongside the strobe so it lines up with the edge detector
   hmp_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_pay_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({host_addr, host_wdata}),
      .q     (pay_s)
   );

   assign {req_s_n, stb_s_n, rw_s} = ctrl_s;
   assign {addr_s, wdata_s}        = pay_s;

   logic stb_prev_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stb_prev_q <= 1'b1;
      end else begin
         stb_prev_q <= stb_s_n;
      end
   end

   logic strobe_fall, granted, wr_en, rd_en;
   assign strobe_fall = stb_prev_q & ~stb_s_n;

   hmp_grant_ctl #(.ON_DLY(GRANT_ON_DLY), .OFF_DLY(GRANT_OFF_DLY)) u_grant (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_act  (~req_s_n),
      .stb_idle (stb_s_n),
      .granted  (granted)
   );

   assign wr_en = strobe_fall & granted & ~rw_s;
   assign rd_en = strobe_fall & granted & rw_s;

   hmp_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (wr_en),
      .re      (rd_en),
      .addr    (addr_s),
      .wdata   (wdata_s),
      .rdata_q (host_rdata)
   );

   assign host_grant_n  = ~granted;
   // raw select gates turn-off at once; synced select gates turn-on
   assign host_rdata_oe = granted & rw_s & host_rw;

   p_grant_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(host_grant_n) |-> $past(!req_s_n))
      else $error("grant without synchronised request");

   p_no_idle_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      host_grant_n |-> !wr_en)
      else $error("write while not granted");

endmodule

// File: tb/host_mem_port_test.sv
module host_mem_port_test;

   localparam int CLK_PERIOD = 10;
   localparam int AW   = 4;
   localparam int DW   = 12;
   localparam int SYNC = 2;
   localparam int ON   = 3;
   localparam int OFF  = 2;
   localparam int LAT_ON  = SYNC + 1 + ON;
   localparam int LAT_OFF = SYNC + 1 + OFF;
   localparam int WORDS   = 1 << AW;

   logic clk = 1'b0;
   logic rst_n;
   logic req_n, grant_n, strobe_n, rw, oe;
   logic [AW-1:0] addr;
   logic [DW-1:0] wdata, rdata;

   int total = 0;
   int bad   = 0;
   bit done  = 0;
   logic [DW-1:0] last_rd;

   always #(CLK_PERIOD / 2) clk = ~clk;

   host_mem_port #(
      .ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(SYNC),
      .GRANT_ON_DLY(ON), .GRANT_OFF_DLY(OFF)
   ) uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .host_req_n    (req_n),
      .host_grant_n  (grant_n),
      .host_strobe_n (strobe_n),
      .host_rw       (rw),
      .host_addr     (addr),
      .host_wdata    (wdata),
      .host_rdata    (rdata),
      .host_rdata_oe (oe)
   );

   function automatic logic [DW-1:0] pat1(input int a);
      return DW'((a * 179 + 21) % 4096);
   endfunction

   function automatic logic [DW-1:0] pat2(input int a);
      return ~pat1(a);
   endfunction

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic acquire();
      req_n = 1'b0;
      for (int i = 1; i <= LAT_ON; i++) begin
         step();
         chk("R2 grant fall latency", 32'(grant_n), (i < LAT_ON) ? 32'd1 : 32'd0);
      end
   endtask

   task automatic release_bus();
      req_n = 1'b1;
      for (int i = 1; i <= LAT_OFF; i++) begin
         step();
         chk("R3 grant rise latency", 32'(grant_n), (i < LAT_OFF) ? 32'd0 : 32'd1);
         chk("R6 enable follows grant", 32'(oe), (i < LAT_OFF) ? 32'(rw) : 32'd0);
      end
   endtask

   task automatic do_write(input int a, input logic [DW-1:0] d);
      rw = 1'b0; addr = AW'(a); wdata = d;
      step(); step();
      strobe_n = 1'b0;
      step();
      addr = ~AW'(a); wdata = ~d;   // R7: late change must be ignored
      for (int i = 0; i < 3; i++) begin
         step();
         chk("R5 no drive during write", 32'(oe), 32'd0);
      end
      strobe_n = 1'b1;
      step(); step(); step();
   endtask

   task automatic do_read(input int a, input logic [DW-1:0] exp);
      rw = 1'b1; addr = AW'(a);
      step();
      if (grant_n == 1'b0) chk("R5 enable waits for sync", 32'(oe), 32'd0);
      step();
      if (grant_n == 1'b0) chk("R5 enable on", 32'(oe), 32'd1);
      strobe_n = 1'b0;
      for (int i = 1; i <= SYNC + 1; i++) begin
         step();
         chk("R9 read data timing", 32'(rdata), (i <= SYNC) ? 32'(last_rd) : 32'(exp));
      end
      last_rd = exp;
      strobe_n = 1'b1;
      for (int i = 0; i < 3; i++) begin
         step();
         chk("R9 read data held", 32'(rdata), 32'(exp));
      end
      rw = 1'b0;
      step(); step(); step();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; req_n = 1'b1; strobe_n = 1'b1; rw = 1'b0;
      addr = '0; wdata = '0; last_rd = '0;
      step(); step(); step();
      rst_n = 1'b1;
      step();
      chk("R1 reset grant", 32'(grant_n), 32'd1);
      chk("R1 reset enable", 32'(oe), 32'd0);
      chk("R1 reset rdata", 32'(rdata), 32'd0);

      // R2: short request pulse aborts inside the arming window
      req_n = 1'b0;
      step(); step();
      req_n = 1'b1;
      for (int i = 0; i < 10; i++) begin
         step();
         chk("R2 aborted request gives no grant", 32'(grant_n), 32'd1);
      end

      acquire();
      for (int a = 0; a < WORDS; a++) do_write(a, pat1(a));
      for (int a = 0; a < WORDS; a++) do_read(a, pat1(a));
      release_bus();

      // R8: strobes without grant
      do_write(5, 12'h0AB);
      do_write(9, 12'h0CD);
      acquire();
      do_read(5, pat1(5));
      do_read(9, pat1(9));

      for (int a = 0; a < WORDS; a++) do_write(a, pat2(a));
      for (int a = 0; a < WORDS; a++) do_read(a, pat2(a));

      // R4: strobe held low blocks release
      rw = 1'b1; addr = '0;
      step(); step();
      strobe_n = 1'b0;
      step(); step(); step(); step();
      last_rd = pat2(0);
      chk("R9 read during hold", 32'(rdata), 32'(last_rd));
      rw = 1'b0;
      req_n = 1'b1;
      for (int i = 0; i < 10; i++) begin
         step();
         chk("R4 grant kept while strobe low", 32'(grant_n), 32'd0);
      end
      strobe_n = 1'b1;
      for (int i = 1; i <= LAT_OFF; i++) begin
         step();
         chk("R4 grant rise after strobe", 32'(grant_n), (i < LAT_OFF) ? 32'd0 : 32'd1);
      end

      // R6: enable drops with grant while reading
      acquire();
      rw = 1'b1;
      step(); step();
      chk("R5 enable on before release", 32'(oe), 32'd1);
      release_bus();
      chk("R6 enable off after release", 32'(oe), 32'd0);

      // R5: immediate turn-off when select goes low
      acquire();
      step(); step();
      chk("R5 enable on", 32'(oe), 32'd1);
      rw = 1'b0;
      #1;
      chk("R5 immediate turn-off", 32'(oe), 32'd0);
      step();
      chk("R5 stays off", 32'(oe), 32'd0);
      release_bus();

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule